// File: doc/BRIEF.md
# Paged Effective Address Unit

This block works out the 12-bit operand address of a memory-reference instruction. The sequencer hands it the instruction's indirect flag, its page-select flag and its 7-bit in-page offset, together with the address from which the instruction was fetched. A direct reference is resolved combinationally. The offset lands either in page zero or in the page that holds the instruction.

When the instruction asks for an indirect reference, the block fetches a pointer word through its memory port and returns that word as the operand address. Eight pointer locations increment themselves: when the in-page address falls in octal 0010 through 0017, the fetched word is incremented, the new value is written back to the same location, and the new value is the one handed to the sequencer.

A one-cycle `start` request launches the work and a one-cycle `done` pulse marks the cycle in which `eff_addr` is valid. The memory port assumes a store that returns read data on the clock edge after the read request and commits writes on the clock edge.

Top module: `paged_ea_unit`

## Requirements
- R1: With `page_sel` = 0, the direct address is five zero bits followed by the 7-bit `offset` (page zero).
- R2: With `page_sel` = 1, the direct address is the upper five bits of `fetch_addr` followed by `offset`. The upper five bits are `fetch_addr[11:7]`, and `offset` fills bits 6:0.
- R3: With `indirect` = 0, `done` is high in the same cycle as `start`, `eff_addr` equals the direct address, and neither `mem_rd` nor `mem_wr` is asserted.
- R4: With `indirect` = 1, the start cycle asserts `mem_rd` with `mem_addr` set to the direct address. In the next cycle `done` is high and `eff_addr` equals `mem_rdata`. Outside octal 0010 to 0017, no write is made.
- R5: With `indirect` = 1 and the direct address in octal 0010 to 0017, the cycle after the read asserts `mem_wr` to the same address with `mem_wdata` equal to the read word plus one. In that same cycle `done` is high and `eff_addr` equals the incremented word. Octal 0007 and 0020 are not incremented.
- R6: Incrementing a pointer word of octal 7777 gives 0000, both in the write-back and in `eff_addr`.
- R7: A `start` raised in the cycle that completes an indirect reference is ignored. No second read is issued and `done` stays high for that one cycle only.
- R8: While `rst_n` is low, and in the first cycle after reset without `start`, `done`, `mem_rd` and `mem_wr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request for one address computation |
| indirect | input | 1 | Indirect flag of the instruction |
| page_sel | input | 1 | 0 selects page zero, 1 selects the instruction's page |
| offset | input | 7 | In-page word offset |
| fetch_addr | input | 12 | Address the instruction was fetched from |
| done | output | 1 | Effective address valid this cycle |
| eff_addr | output | 12 | Effective operand address |
| mem_rd | output | 1 | Read request, data expected next cycle |
| mem_wr | output | 1 | Write request |
| mem_addr | output | 12 | Memory address |
| mem_wdata | output | 12 | Write data |
| mem_rdata | input | 12 | Read data |

## Verification
The pointer write-back and the completion pulse fall in the same cycle for an auto-increment reference. The bench drives indirect references whose direct address lies inside and just outside the octal 0010 to 0017 window, on both page selections. In the completion cycle it checks that `mem_wr`, `mem_wdata` and `done` with the incremented `eff_addr` appear together. It then reads its own memory model to confirm that the stored pointer advanced, including the 7777 to 0000 wrap. A second collision, a new `start` landing on the completion cycle, is provoked directly and judged by the absence of a second read and of a second `done`.

// File: rtl/paged_ea_unit.sv
module paged_ea_unit #(
  parameter int AW      = 12,
  parameter int OFFW    = 7,
  parameter int AUTO_LO = 8,
  parameter int AUTO_HI = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          indirect,
  input  logic          page_sel,
  input  logic [OFFW-1:0] offset,
  input  logic [AW-1:0] fetch_addr,
  output logic          done,
  output logic [AW-1:0] eff_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  input  logic [AW-1:0] mem_rdata
);
  localparam int PAGEW = AW - OFFW;

  logic          busy, auto_q;
  logic [AW-1:0] ptr_q, dir_addr, bumped;
  logic          accept, auto_hit;

  assign dir_addr = page_sel ? {fetch_addr[AW-1 -: PAGEW], offset}
                             : {{PAGEW{1'b0}}, offset};
  assign auto_hit = (dir_addr >= AW'(AUTO_LO)) && (dir_addr <= AW'(AUTO_HI));
  assign accept   = start && !busy;
  assign bumped   = mem_rdata + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      auto_q <= 1'b0;
      ptr_q  <= '0;
    end else if (accept && indirect) begin
      busy   <= 1'b1;
      auto_q <= auto_hit;
      ptr_q  <= dir_addr;
    end else begin
      busy   <= 1'b0;
      auto_q <= 1'b0;
    end
  end

  assign mem_rd    = accept && indirect;
  assign mem_wr    = busy && auto_q;
  assign mem_addr  = busy ? ptr_q : dir_addr;
  assign mem_wdata = bumped;
  assign done      = busy || (accept && !indirect);
  assign eff_addr  = busy ? (auto_q ? bumped : mem_rdata) : dir_addr;

  p_read_then_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> done);
  p_no_back_to_back_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);
  p_write_in_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_addr >= AW'(AUTO_LO) && mem_addr <= AW'(AUTO_HI)));
  p_write_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd));
  p_write_addr_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> mem_addr == $past(mem_addr));
  p_direct_no_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !indirect && !$past(mem_rd)) |-> (done && !mem_rd && !mem_wr));
  p_rw_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
endmodule

// File: tb/sim_paged_ea_unit.sv
module sim_paged_ea_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, indirect = 0, page_sel = 0;
  logic [6:0] offset = '0;
  logic [11:0] fetch_addr = '0, mem_rdata;
  logic done, mem_rd, mem_wr;
  logic [11:0] eff_addr, mem_addr, mem_wdata;
  logic [11:0] mem [4096];
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  paged_ea_unit u0 (.clk(clk), .rst_n(rst_n), .start(start), .indirect(indirect),
    .page_sel(page_sel), .offset(offset), .fetch_addr(fetch_addr), .done(done),
    .eff_addr(eff_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_wr) mem[mem_addr] <= mem_wdata;
  end

  task automatic chk(input logic ok, input string tag, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%o expected=%o", tag, act, exp);
    end
  endtask

  // ind, psel, offset, fetch, stored word, expected EA, expect write
  localparam logic [45:0] VEC [10] = '{
    {1'b0, 1'b0, 7'o105, 12'o3456, 12'o0000, 12'o0105, 1'b0},
    {1'b0, 1'b1, 7'o105, 12'o3456, 12'o0000, 12'o3505, 1'b0},
    {1'b0, 1'b1, 7'o000, 12'o7777, 12'o0000, 12'o7600, 1'b0},
    {1'b1, 1'b0, 7'o007, 12'o1000, 12'o4321, 12'o4321, 1'b0},
    {1'b1, 1'b0, 7'o010, 12'o1000, 12'o0100, 12'o0101, 1'b1},
    {1'b1, 1'b0, 7'o017, 12'o1000, 12'o2222, 12'o2223, 1'b1},
    {1'b1, 1'b0, 7'o020, 12'o1000, 12'o1111, 12'o1111, 1'b0},
    {1'b1, 1'b1, 7'o012, 12'o0050, 12'o0300, 12'o0301, 1'b1},
    {1'b1, 1'b1, 7'o012, 12'o0200, 12'o5555, 12'o5555, 1'b0},
    {1'b1, 1'b0, 7'o015, 12'o0000, 12'o7777, 12'o0000, 1'b1}
  };

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [11:0] dir, word;
    for (int a = 0; a < 4096; a++) mem[a] = 12'o0;
    repeat (3) @(negedge clk);
    chk(!done && !mem_rd && !mem_wr, "R8 outputs low in reset", {9'd0, done, mem_rd, mem_wr}, 12'o0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!done && !mem_rd && !mem_wr, "R8 idle after reset", {9'd0, done, mem_rd, mem_wr}, 12'o0);

    for (int i = 0; i < 10; i++) begin
      logic [45:0] v;
      v = VEC[i];
      dir = v[44] ? {v[36:32], v[43:37]} : {5'b0, v[43:37]};
      word = v[24:13];
      mem[dir] = word;
      @(negedge clk);
      start = 1; indirect = v[45]; page_sel = v[44]; offset = v[43:37]; fetch_addr = v[36:25];
      #1;
      if (!v[45]) begin
        chk(done && eff_addr == v[12:1], v[44] ? "R2 current page" : "R1 page zero", eff_addr, v[12:1]);
        chk(!mem_rd && !mem_wr, "R3 direct no access", {10'd0, mem_rd, mem_wr}, 12'o0);
        @(negedge clk); start = 0; #1;
        chk(!done, "R3 single done", {11'd0, done}, 12'o0);
      end else begin
        chk(mem_rd && !done && mem_addr == dir, v[44] ? "R2 R4 pointer addr" : "R1 R4 pointer addr", mem_addr, dir);
        @(negedge clk); start = 0; #1;
        chk(done && eff_addr == v[12:1], v[0] ? "R5 incremented EA" : "R4 plain EA", eff_addr, v[12:1]);
        chk(mem_wr == v[0], "R5 write-back flag", {11'd0, mem_wr}, {11'd0, v[0]});
        if (v[0]) chk(mem_wdata == v[12:1] && mem_addr == dir, "R5 write data", mem_wdata, v[12:1]);
        @(negedge clk); #1;
        chk(!done && !mem_wr, "R4 one done pulse", {10'd0, done, mem_wr}, 12'o0);
        chk(mem[dir] == (v[0] ? v[12:1] : word), v[12:1] == 12'o0 ? "R6 wrap stored" : "R5 stored pointer", mem[dir], v[0] ? v[12:1] : word);
      end
    end

    mem[12'o0030] = 12'o0444;
    @(negedge clk);
    start = 1; indirect = 1; page_sel = 0; offset = 7'o030; #1;
    chk(mem_rd, "R7 first read", {11'd0, mem_rd}, 12'o1);
    @(negedge clk); #1;
    chk(!mem_rd && done && eff_addr == 12'o0444, "R7 start ignored when finishing", eff_addr, 12'o0444);
    @(negedge clk); start = 0; #1;
    chk(!done && !mem_rd, "R7 no second done", {10'd0, done, mem_rd}, 12'o0);

    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule